// File: doc/BRIEF.md
# Concurrent error detection outcome classifier

This block measures how well a self-checking arithmetic unit behaves when its gates fail. It holds a small parity-checked ripple-carry adder in which every gate output can be inverted by its own saboteur bit. A separate, fault-free copy of the addition computes the true result. For each sampled operand set, the block decides two things. The first is whether the sabotaged adder's result is actually right. The second is whether the sabotaged checker claims it is right. It then adds one to the counter for that combination.

The four counters keep apart correct results that the checker accepts, false alarms, missed errors and detected errors. Effective reliability is the accepted-and-correct count divided by the sum of the accepted counts. Time penalty is the sum of the two rejected counts. Software forms both quotients from the counters. A fault pattern is written into a mask register, and a stream of operand sets is then applied to measure that pattern.

Top module: `ced_outcome_classifier`

## Requirements
- R1: After reset every counter reads zero and the fault mask is all zeros. The reset input is asynchronous and active-low, and the block leaves reset two clock edges after `rst_n` rises.
- R2: A result counts as correct only when {`sum_cout`, `sum`} of the sabotaged adder equals `op_a + op_b + carry_in` computed at W+1 bits without faults. The carry-out is part of the result.
- R3: The checker predicts the sum parity as the XOR of all bits of `op_a`, all bits of `op_b` and the adder's internal carries into each bit position. Carry 0 is `carry_in`, and the others are the sabotaged adder's own carries. It reports valid when the predicted parity equals the XOR of the sum bits.
- R4: A mask bit at 1 inverts exactly one gate output. Full-adder bit i uses mask[5i] for a^b, mask[5i+1] for the sum XOR, mask[5i+2] for a&b, mask[5i+3] for the propagate AND and mask[5i+4] for the carry OR. The prediction XOR chain takes inputs in the order a bits, b bits, carries, and its gate j (j from 1) uses mask[5W+j-1]. The sum-parity chain gate j uses mask[8W-2+j]. The final comparison gate uses mask[9W-2].
- R5: When `mask_we` is high at a clock edge, `mask_wdata` is loaded at that edge. A sample taken at the same edge is still judged with the previous mask.
- R6: The outcome code is xi (index 0) for correct and valid, tau (1) for correct and not valid, psi (2) for incorrect and valid, and chi (3) for incorrect and not valid. A counter value changes on the clock edge at which `sample_valid` is high, and the new value is visible right after that edge.
- R7: On every accepted sample, exactly one counter advances. While no counter is saturated, the sum of the four counters equals the number of samples taken since the last clear.
- R8: A high `clear` sets all four counters to zero at that clock edge and takes priority over a sample at the same edge.
- R9: A counter that holds its maximum value 2^CNT_W-1 stays there on further samples and does not wrap.
- R10: When `sample_valid` and `clear` are low, all counters hold, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_we | input | 1 | Load strobe for the fault mask |
| mask_wdata | input | 9W-1 | New fault mask, one bit per gate |
| sample_valid | input | 1 | Classify the current operands at this edge |
| op_a | input | W | First addend |
| op_b | input | W | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| clear | input | 1 | Synchronous clear of all counters |
| cnt_xi | output | CNT_W | Correct and accepted |
| cnt_tau | output | CNT_W | Correct but rejected (false alarm) |
| cnt_psi | output | CNT_W | Wrong but accepted (missed error) |
| cnt_chi | output | CNT_W | Wrong and rejected |

## Verification
The assertions rely on the control inputs being clean binary values at every sampling edge, and on the mask changing only through `mask_we`. The counting properties also rely on at most one sample per cycle. The bench drives every input from tasks on the falling edge. It applies samples only after the reset synchronizer has released, and it drives `clear` and `sample_valid` together only where the priority rule is being tested on purpose. Operand sweeps run over every combination of the 4-bit inputs for single-gate faults placed on sum, carry, carry-out and comparison gates. Random sparse masks then mix idle cycles, mask reloads during sampling, and a long fault-free run that drives one counter into saturation.

// File: rtl/ced_pkg.sv
package ced_pkg;

  typedef enum logic [1:0] {
    OUT_XI  = 2'd0,
    OUT_TAU = 2'd1,
    OUT_PSI = 2'd2,
    OUT_CHI = 2'd3
  } outcome_e;

  localparam int unsigned FA_SITES  = 5;
  localparam int unsigned N_OUTCOME = 4;

  function automatic int unsigned adder_sites(input int unsigned w);
    return FA_SITES * w;
  endfunction

  function automatic int unsigned checker_sites(input int unsigned w);
    return 4 * w - 1;
  endfunction

endpackage

// File: rtl/sab_ripple_adder.sv
module sab_ripple_adder #(
  parameter int W = 4,
  localparam int MA = 5 * W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          cin,
  input  logic [MA-1:0] flip,
  output logic [W-1:0]  sum,
  output logic          cout,
  output logic [W-1:0]  carries
);

  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic half_x;
    logic gen_t;
    logic prop_t;
    assign half_x   = (a[i] ^ b[i]) ^ flip[5*i];
    assign sum[i]   = (half_x ^ c[i]) ^ flip[5*i+1];
    assign gen_t    = (a[i] & b[i]) ^ flip[5*i+2];
    assign prop_t   = (half_x & c[i]) ^ flip[5*i+3];
    assign c[i+1]   = (gen_t | prop_t) ^ flip[5*i+4];
  end

  assign cout    = c[W];
  assign carries = c[W-1:0];

endmodule

// File: rtl/sab_parity_checker.sv
module sab_parity_checker #(
  parameter int W = 4,
  localparam int PN = 3 * W,
  localparam int MC = 4 * W - 1
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [W-1:0]  carries,
  input  logic [W-1:0]  sum,
  input  logic [MC-1:0] flip,
  output logic          valid
);

  logic [PN-1:0] pin;
  logic [PN-1:0] pred_acc;
  logic [W-1:0]  act_acc;

  assign pin         = {carries, b, a};
  assign pred_acc[0] = pin[0];

  for (genvar j = 1; j < PN; j++) begin : g_pred
    assign pred_acc[j] = (pred_acc[j-1] ^ pin[j]) ^ flip[j-1];
  end

  assign act_acc[0] = sum[0];

  for (genvar j = 1; j < W; j++) begin : g_act
    assign act_acc[j] = (act_acc[j-1] ^ sum[j]) ^ flip[PN-2+j];
  end

  assign valid = ~(pred_acc[PN-1] ^ act_acc[W-1]) ^ flip[MC-1];

endmodule

// File: rtl/ced_outcome_sort.sv
module ced_outcome_sort
  import ced_pkg::*;
(
  input  logic        sample_en,
  input  logic        correct,
  input  logic        valid,
  output outcome_e    cat,
  output logic [3:0]  hit
);

  always_comb begin
    if (correct) cat = valid ? OUT_XI  : OUT_TAU;
    else         cat = valid ? OUT_PSI : OUT_CHI;
    hit = sample_en ? (4'b0001 << cat) : 4'b0000;
  end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = cnt_q;
    if (clr)                          cnt_d = '0;
    else if (inc && (cnt_q != '1))    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/ced_outcome_classifier.sv
module ced_outcome_classifier
  import ced_pkg::*;
#(
  parameter int W = 4,
  parameter int CNT_W = 16,
  localparam int MA = adder_sites(W),
  localparam int MC = checker_sites(W),
  localparam int MW = MA + MC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic [MW-1:0]    mask_wdata,
  input  logic             sample_valid,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic             carry_in,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt_xi,
  output logic [CNT_W-1:0] cnt_tau,
  output logic [CNT_W-1:0] cnt_psi,
  output logic [CNT_W-1:0] cnt_chi
);

  // reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // fault mask register
  logic [MW-1:0] mask_q;
  logic [MW-1:0] mask_d;

  always_comb begin
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  // fault-prone datapath and checker
  logic [W-1:0] dut_sum;
  logic         dut_cout;
  logic [W-1:0] dut_carries;
  logic         chk_valid;

  sab_ripple_adder #(.W(W)) u_adder (
    .a       (op_a),
    .b       (op_b),
    .cin     (carry_in),
    .flip    (mask_q[MA-1:0]),
    .sum     (dut_sum),
    .cout    (dut_cout),
    .carries (dut_carries)
  );

  sab_parity_checker #(.W(W)) u_checker (
    .a       (op_a),
    .b       (op_b),
    .carries (dut_carries),
    .sum     (dut_sum),
    .flip    (mask_q[MW-1:MA]),
    .valid   (chk_valid)
  );

  // fault-free reference
  logic [W:0] gold_total;
  logic       out_correct;

  assign gold_total  = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
  assign out_correct = ({dut_cout, dut_sum} == gold_total);

  // classification
  logic       sample_en;
  outcome_e   sample_cat;
  logic [3:0] cat_hit;

  assign sample_en = sample_valid & ~clear;

  ced_outcome_sort u_sort (
    .sample_en (sample_en),
    .correct   (out_correct),
    .valid     (chk_valid),
    .cat       (sample_cat),
    .hit       (cat_hit)
  );

  // outcome counters
  logic [CNT_W-1:0] tally [N_OUTCOME];

  for (genvar k = 0; k < N_OUTCOME; k++) begin : g_cnt
    sat_counter #(.CW(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (clear),
      .inc   (cat_hit[k]),
      .count (tally[k])
    );
  end

  assign cnt_xi  = tally[OUT_XI];
  assign cnt_tau = tally[OUT_TAU];
  assign cnt_psi = tally[OUT_PSI];
  assign cnt_chi = tally[OUT_CHI];

endmodule

// File: rtl/ced_outcome_classifier_sva.sv
module ced_outcome_classifier_sva #(
  parameter int CNT_W = 16,
  parameter int MW = 35
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mask_we,
  input logic [MW-1:0]    mask_q,
  input logic             sample_valid,
  input logic             clear,
  input logic             out_correct,
  input logic             chk_valid,
  input logic [CNT_W-1:0] cnt_xi,
  input logic [CNT_W-1:0] cnt_tau,
  input logic [CNT_W-1:0] cnt_psi,
  input logic [CNT_W-1:0] cnt_chi
);

  localparam logic [CNT_W-1:0] CAP = '1;

  logic none_full;
  assign none_full = (cnt_xi != CAP) && (cnt_tau != CAP) &&
                     (cnt_psi != CAP) && (cnt_chi != CAP);

  // R7: one counter moves per accepted sample
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !clear && none_full) |=>
      ($countones({cnt_xi != $past(cnt_xi), cnt_tau != $past(cnt_tau),
                   cnt_psi != $past(cnt_psi), cnt_chi != $past(cnt_chi)}) == 1));

  // R6: correct and accepted lands in xi
  a_r6_xi_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !clear && out_correct && chk_valid && cnt_xi != CAP) |=>
      (cnt_xi == CNT_W'($past(cnt_xi) + 1'b1)));

  // R6: wrong but accepted lands in psi
  a_r6_psi_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !clear && !out_correct && chk_valid && cnt_psi != CAP) |=>
      (cnt_psi == CNT_W'($past(cnt_psi) + 1'b1)));

  // R8: clear empties every counter
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_xi == '0 && cnt_tau == '0 && cnt_psi == '0 && cnt_chi == '0));

  // R9: saturated counters stay saturated
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && (cnt_xi == CAP || cnt_tau == CAP || cnt_psi == CAP || cnt_chi == CAP)) |=>
      (($past(cnt_xi) != CAP || cnt_xi == CAP) && ($past(cnt_tau) != CAP || cnt_tau == CAP) &&
       ($past(cnt_psi) != CAP || cnt_psi == CAP) && ($past(cnt_chi) != CAP || cnt_chi == CAP)));

  // R10: idle cycles leave the counters alone
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !clear) |=>
      ($stable(cnt_xi) && $stable(cnt_tau) && $stable(cnt_psi) && $stable(cnt_chi)));

  // R5: the mask only changes on a write
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

endmodule

bind ced_outcome_classifier ced_outcome_classifier_sva #(.CNT_W(CNT_W), .MW(MW)) u_sva (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .mask_we      (mask_we),
  .mask_q       (mask_q),
  .sample_valid (sample_valid),
  .clear        (clear),
  .out_correct  (out_correct),
  .chk_valid    (chk_valid),
  .cnt_xi       (cnt_xi),
  .cnt_tau      (cnt_tau),
  .cnt_psi      (cnt_psi),
  .cnt_chi      (cnt_chi)
);

// File: tb/ced_outcome_classifier_test.sv
`timescale 1ns/1ps
module ced_outcome_classifier_test;

  localparam int W = 4;
  localparam int CNT_W = 10;
  localparam int MW = 9 * W - 1;
  localparam int CAP = (1 << CNT_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             mask_we;
  logic [MW-1:0]    mask_wdata;
  logic             sample_valid;
  logic [W-1:0]     op_a;
  logic [W-1:0]     op_b;
  logic             carry_in;
  logic             clear;
  logic [CNT_W-1:0] cnt_xi, cnt_tau, cnt_psi, cnt_chi;

  ced_outcome_classifier #(.W(W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .sample_valid(sample_valid), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .clear(clear), .cnt_xi(cnt_xi), .cnt_tau(cnt_tau), .cnt_psi(cnt_psi), .cnt_chi(cnt_chi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  int m_cnt [4];
  logic [MW-1:0] m_mask;

  // behavioural evaluation of one sample per R2, R3, R4, R6
  function automatic int model_cat(input logic [MW-1:0] m, input logic [W-1:0] a,
                                   input logic [W-1:0] b, input logic ci);
    logic [W:0]   c;
    logic [W-1:0] s;
    logic h, g, p, pp, ap, vld, ok, bitv;
    int idx;
    c[0] = ci;
    for (int i = 0; i < W; i++) begin
      h      = a[i] ^ b[i] ^ m[5*i];
      s[i]   = h ^ c[i] ^ m[5*i+1];
      g      = (a[i] & b[i]) ^ m[5*i+2];
      p      = (h & c[i]) ^ m[5*i+3];
      c[i+1] = (g | p) ^ m[5*i+4];
    end
    ok  = ({c[W], s} == ((W+1)'(a) + (W+1)'(b) + (W+1)'(ci)));
    pp  = a[0];
    idx = 5 * W;
    for (int j = 1; j < 3 * W; j++) begin
      if (j < W)          bitv = a[j];
      else if (j < 2 * W) bitv = b[j-W];
      else                bitv = c[j-2*W];
      pp = pp ^ bitv ^ m[idx];
      idx++;
    end
    ap = s[0];
    for (int j = 1; j < W; j++) begin
      ap = ap ^ s[j] ^ m[idx];
      idx++;
    end
    vld = ~(pp ^ ap) ^ m[idx];
    if (ok) return vld ? 0 : 1;
    return vld ? 2 : 3;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    n_checks++;
    if (cnt_xi != m_cnt[0] || cnt_tau != m_cnt[1] || cnt_psi != m_cnt[2] || cnt_chi != m_cnt[3]) begin
      n_errors++;
      $display("FAIL %s actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d", req,
               cnt_xi, cnt_tau, cnt_psi, cnt_chi, m_cnt[0], m_cnt[1], m_cnt[2], m_cnt[3]);
    end
  endtask

  task automatic cyc(input logic sv, input logic clr, input logic mwe, input logic [MW-1:0] mw,
                     input logic [W-1:0] a, input logic [W-1:0] b, input logic ci, input string req);
    int k;
    @(negedge clk);
    sample_valid = sv; clear = clr; mask_we = mwe; mask_wdata = mw;
    op_a = a; op_b = b; carry_in = ci;
    @(posedge clk);
    if (clr) begin
      for (int q = 0; q < 4; q++) m_cnt[q] = 0;
    end else if (sv) begin
      k = model_cat(m_mask, a, b, ci);
      if (m_cnt[k] < CAP) m_cnt[k]++;
    end
    if (mwe) m_mask = mw;
    #1;
    check_all(req);
  endtask

  task automatic sweep(input logic [MW-1:0] m, input string req);
    for (int v = 0; v < (1 << (2 * W + 1)); v++)
      cyc(1'b1, 1'b0, 1'b0, m, v[W-1:0], v[2*W-1:W], v[2*W], req);
  endtask

  task automatic do_clear();
    cyc(1'b0, 1'b1, 1'b0, '0, '0, '0, 1'b0, "R8");
  endtask

  task automatic load_mask(input logic [MW-1:0] m);
    cyc(1'b0, 1'b0, 1'b1, m, '0, '0, 1'b0, "R5");
  endtask

  function automatic logic [MW-1:0] one_bit(input int pos);
    logic [MW-1:0] r;
    r = '0;
    r[pos] = 1'b1;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL R7 watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < 4; q++) m_cnt[q] = 0;
    m_mask = '0;
    rst_n = 1'b0; mask_we = 1'b0; mask_wdata = '0; sample_valid = 1'b0;
    op_a = '0; op_b = '0; carry_in = 1'b0; clear = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 after release");

    // fault-free: everything correct and accepted (R2, R6, R7)
    sweep('0, "R6 fault-free");
    check("R7 sum equals samples", cnt_xi + cnt_tau + cnt_psi + cnt_chi, 512);
    check("R2 fault-free xi", cnt_xi, 512);
    do_clear();
    check("R8 cleared", cnt_xi, 0);

    // R5: sample in the load cycle uses the old (zero) mask
    cyc(1'b1, 1'b0, 1'b1, one_bit(1), 4'd3, 4'd5, 1'b0, "R5 same-edge");
    check("R5 old mask used", cnt_xi, 1);
    do_clear();

    // sum XOR fault in bit 0: wrong result, parity flips -> chi (R4, R6)
    sweep(m_mask, "R4 sum fault");
    check("R6 sum fault chi", cnt_chi, 512);
    do_clear();

    // comparison gate fault: correct results rejected -> tau (R3)
    load_mask(one_bit(9 * W - 2));
    sweep(m_mask, "R3 compare fault");
    check("R3 compare fault tau", cnt_tau, 512);
    do_clear();

    // carry-out OR of top bit: carry-out is not covered by parity -> psi (R2)
    load_mask(one_bit(5 * (W - 1) + 4));
    sweep(m_mask, "R2 cout fault");
    check("R2 cout fault psi", cnt_psi, 512);
    do_clear();

    // carry OR of bit 0: sum and prediction flip together -> psi (R3)
    load_mask(one_bit(4));
    sweep(m_mask, "R3 shared carry");
    check("R3 shared carry psi", cnt_psi, 512);
    do_clear();

    // random sparse masks, idle cycles, clear with sample
    for (int t = 0; t < 3000; t++) begin
      int sel;
      logic [MW-1:0] rm;
      sel = int'($urandom_range(0, 9));
      rm  = MW'({$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()});
      if (sel == 0)      cyc(1'b0, 1'b0, 1'b1, rm, 4'($urandom()), 4'($urandom()), 1'($urandom()), "R5 reload");
      else if (sel == 1) cyc(1'b0, 1'b0, 1'b0, rm, 4'($urandom()), 4'($urandom()), 1'($urandom()), "R10 idle");
      else if (sel == 2 && t % 7 == 0) cyc(1'b1, 1'b1, 1'b0, rm, 4'($urandom()), 4'($urandom()), 1'($urandom()), "R8 priority");
      else if (sel == 3) cyc(1'b1, 1'b0, 1'b1, rm, 4'($urandom()), 4'($urandom()), 1'($urandom()), "R5 load+sample");
      else cyc(1'b1, 1'b0, 1'b0, rm, 4'($urandom()), 4'($urandom()), 1'($urandom()), "R6 random");
    end

    // idle with changing operands holds the counters (R10)
    begin
      int h0;
      h0 = cnt_xi + cnt_tau + cnt_psi + cnt_chi;
      for (int t = 0; t < 20; t++) cyc(1'b0, 1'b0, 1'b0, '0, 4'(t), 4'(t + 3), 1'(t), "R10 hold");
      check("R10 total held", cnt_xi + cnt_tau + cnt_psi + cnt_chi, h0);
    end

    // saturation (R9)
    do_clear();
    load_mask('0);
    for (int t = 0; t < CAP + 80; t++) cyc(1'b1, 1'b0, 1'b0, '0, 4'(t), 4'(t >> 4), 1'(t >> 8), "R9 saturate");
    check("R9 xi at max", cnt_xi, CAP);
    check("R9 others zero", cnt_tau + cnt_psi + cnt_chi, 0);
    do_clear();
    check("R8 clear after saturation", cnt_xi, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule